// File: doc/BRIEF.md
# Command/Indicate Status Signalling Output

This block is the slave-side source of the 6-bit command/indicate field in channel 1 of a time-multiplexed serial control bus. From an 8-bit status word, an 8-bit interrupt mask and a 3-bit output control code it forms a 6-bit field and shifts it onto an active-low serial data line inside its slot of each frame. Outside the slot the line is released (held at 1), so other slaves and other channels can share it.

The control code picks one of three modes. The field can be disabled (all ones), so that other slaves may use every bit. It can carry one active-low interrupt request on a chosen bit. Or it can carry the six upper status bits directly. The slave never starts an exchange itself. A change of the field tells the master to read the status word. The block runs on the bus data clock, which toggles at twice the bit rate. A frame begins at the rising edge of frame sync.

Top module: `ci_status_out`

## Requirements
- R1: After reset the register stage holds code 000, status 0 and mask 0, and `sd_o` is 1 until a frame has started.
- R2: Code 000 gives field 6'b111111 for any status and mask value.
- R3: Code n in the range 001 to 110 drives field bit n-1 to 0 when any bit of status[7:2] & mask[7:2] is 1. All other field bits are 1. A mask bit of 1 enables its status bit.
- R4: Status bits 1 and 0 never change the field, whatever the code or mask.
- R5: Code 111 sets field bit i to status[i+2] & mask[i+2] for i = 0..5, so a masked bit is held at 0.
- R6: A rising edge of `fsync_i` starts a frame. Field bit 5-j is on `sd_o` for data-clock periods 2*(SLOT_OFS+j) and 2*(SLOT_OFS+j)+1, counted from the period after the edge that sampled the rise. Each bit lasts two clocks, and the field is sent MSB first.
- R7: Outside the 12 slot periods, and before the first frame, `sd_o` is 1.
- R8: Configuration inputs pass through one register stage. The field is captured one clock before the slot begins, so a change made during the slot shows up only in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus data clock (twice the bit rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync; rising edge starts a frame |
| code_i | input | 3 | Output control code |
| status_i | input | ST_W | Status word |
| mask_i | input | ST_W | Interrupt mask, 1 = enabled |
| sd_o | output | 1 | Serial data, active low, 1 outside the slot |

## Verification
A fixed table covers each mode with status and mask words that separate its cases. Status bits inside and outside the upper six, masks that cancel the status, and asymmetric direct patterns expose wrong bit ordering or a wrong selected bit. Random status, mask and code frames are then compared with an independent model of the mapping. Every frame is checked at all bit periods, which confirms the slot position, the two-clock bit width and the idle-high line. A mid-slot change of the status word separates sampling at slot start from live output, and a reset during traffic confirms the idle state.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int CI_W = 6;
  typedef logic [CI_W-1:0] ci_field_t;
  typedef enum logic [2:0] {
    CODE_OFF    = 3'd0,
    CODE_DIRECT = 3'd7
  } ci_code_e;
endpackage

// File: rtl/ci_map.sv
module ci_map
  import ci_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      code_i,
  input  logic [ST_W-1:0] status_i,
  input  logic [ST_W-1:0] mask_i,
  output ci_field_t       field_o
);
  localparam int LSB = ST_W - CI_W;

  ci_field_t act;
  ci_field_t irq_sel;
  logic      req;

  assign act = status_i[ST_W-1:LSB] & mask_i[ST_W-1:LSB];
  assign req = |act;

  for (genvar i = 0; i < CI_W; i++) begin : g_sel
    assign irq_sel[i] = (code_i == 3'(i + 1));
  end

  always_comb begin
    unique case (code_i)
      CODE_OFF:    field_o = '1;
      CODE_DIRECT: field_o = act;
      default:     field_o = ~(irq_sel & {CI_W{req}});
    endcase
  end

  a_r2_off_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == CODE_OFF) |-> (field_o == '1));
  a_r3_single_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != CODE_OFF && code_i != CODE_DIRECT) |-> ($countones(~field_o) <= 1));
  a_r5_masked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == CODE_DIRECT) |-> ((field_o & ~mask_i[ST_W-1:LSB]) == '0));
endmodule

// File: rtl/ci_frame_ctr.sv
module ci_frame_ctr
  import ci_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  parameter int SLOT_OFS   = 58
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  output logic load_o,
  output logic shift_o,
  output logic in_slot_o
);
  localparam int HALVES = 2 * FRAME_BITS;
  localparam int CW     = $clog2(HALVES + 1);
  localparam logic [CW-1:0] LAST = CW'(HALVES - 1);
  localparam logic [CW-1:0] S0   = CW'(2 * SLOT_OFS);
  localparam logic [CW-1:0] S1   = CW'(2 * (SLOT_OFS + CI_W));
  localparam logic [CW-1:0] S0M1 = CW'((SLOT_OFS == 0) ? 0 : 2 * SLOT_OFS - 1);

  logic          fs_q;
  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = fsync_i & ~fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fs_q <= fsync_i;
      if (rise) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q && cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_slot_o = run_q && (cnt_q >= S0) && (cnt_q < S1);
  assign shift_o   = in_slot_o && cnt_q[0];

  if (SLOT_OFS == 0) begin : g_ofs_zero
    assign load_o = rise;
  end else begin : g_ofs_pos
    assign load_o = run_q && !rise && (cnt_q == S0M1);
  end

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (cnt_q == '0 && run_q));
  a_r6_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !rise && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ci_shift.sv
module ci_shift
  import ci_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      shift_i,
  input  ci_field_t d_i,
  output logic      msb_o
);
  ci_field_t sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '1;
    else if (load_i)  sreg_q <= d_i;
    else if (shift_i) sreg_q <= {sreg_q[CI_W-2:0], 1'b1};
  end

  assign msb_o = sreg_q[CI_W-1];

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sreg_q == $past(d_i)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sreg_q));
endmodule

// File: rtl/ci_status_out.sv
module ci_status_out
  import ci_pkg::*;
#(
  parameter int FRAME_BITS = 96,
  parameter int SLOT_OFS   = 58,
  parameter int ST_W       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fsync_i,
  input  logic [2:0]      code_i,
  input  logic [ST_W-1:0] status_i,
  input  logic [ST_W-1:0] mask_i,
  output logic            sd_o
);
  logic [2:0]      code_q;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] mask_q;
  ci_field_t       field;
  logic            load, shift, in_slot, msb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= CODE_OFF;
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      code_q   <= code_i;
      status_q <= status_i;
      mask_q   <= mask_i;
    end
  end

  ci_map #(.ST_W(ST_W)) u_map (
    .clk_i, .rst_ni, .code_i(code_q), .status_i(status_q), .mask_i(mask_q), .field_o(field)
  );

  ci_frame_ctr #(.FRAME_BITS(FRAME_BITS), .SLOT_OFS(SLOT_OFS)) u_ctr (
    .clk_i, .rst_ni, .fsync_i, .load_o(load), .shift_o(shift), .in_slot_o(in_slot)
  );

  ci_shift u_shift (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift), .d_i(field), .msb_o(msb)
  );

  assign sd_o = in_slot ? msb : 1'b1;

  // first half of each bit period is repeated in the second half
  a_r6_two_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_slot && !shift && !fsync_i) |=> $stable(sd_o));
endmodule

// File: tb/ci_status_out_test.sv
module ci_status_out_test;
  localparam int FB = 96;
  localparam int OFS = 58;
  localparam int S0 = 2 * OFS;
  localparam int S1 = S0 + 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fsync = 1'b0;
  logic [2:0] code = '0;
  logic [7:0] status = '0, mask = '0;
  logic sd;

  int checks = 0, fails = 0;
  bit done = 0;

  // mid-slot change request
  bit pend_en = 0;
  logic [7:0] pend_status = '0;

  always #10 clk = ~clk;

  ci_status_out #(.FRAME_BITS(FB), .SLOT_OFS(OFS), .ST_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fsync), .code_i(code),
    .status_i(status), .mask_i(mask), .sd_o(sd)
  );

  // {code, status, mask, expected field}
  localparam logic [24:0] VEC [12] = '{
    {3'b000, 8'hFF, 8'hFF, 6'h3F},
    {3'b001, 8'h04, 8'h04, 6'h3E},
    {3'b001, 8'h04, 8'h00, 6'h3F},
    {3'b011, 8'h80, 8'h80, 6'h3B},
    {3'b110, 8'h03, 8'hFF, 6'h3F},
    {3'b110, 8'h10, 8'h10, 6'h1F},
    {3'b111, 8'hFC, 8'hFF, 6'h3F},
    {3'b111, 8'hFC, 8'h00, 6'h00},
    {3'b111, 8'hA4, 8'hFF, 6'h29},
    {3'b111, 8'hFF, 8'h0C, 6'h03},
    {3'b100, 8'h20, 8'h60, 6'h37},
    {3'b101, 8'h01, 8'h01, 6'h3F}
  };

  function automatic logic [5:0] model(input logic [2:0] c, input logic [7:0] s, input logic [7:0] m);
    logic [5:0] hit = s[7:2] & m[7:2];
    logic [5:0] r = 6'h3F;
    if (c == 3'd7) r = hit;
    else if (c != 3'd0 && hit != 6'h00) r[c - 3'd1] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // runs one frame; returns the field seen, slot bits with unequal halves, and idle-high errors
  task automatic run_frame(output logic [5:0] fld, output int half_err, output int idle_err);
    logic cap [2*FB];
    half_err = 0;
    idle_err = 0;
    @(negedge clk) fsync = 1'b1;
    for (int k = 0; k < 2 * FB; k++) begin
      @(negedge clk);
      cap[k] = sd;
      if (k == 2) fsync = 1'b0;
      if (pend_en && k == S0 + 3) begin
        status = pend_status;
        pend_en = 0;
      end
    end
    for (int k = 0; k < 2 * FB; k++) begin
      if (k >= S0 && k < S1) begin
        if (k[0] == 1'b0) begin
          fld[5 - (k - S0) / 2] = cap[k];
          if (cap[k + 1] !== cap[k]) half_err++;
        end
      end else if (cap[k] !== 1'b1) begin
        idle_err++;
      end
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [7:0] s, input logic [7:0] m);
    @(negedge clk);
    code = c; status = s; mask = m;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] f;
    int he, ie;
    int idle_bad;

    // R1 / R7: line idle through reset and before any frame
    code = 3'd7; status = 8'hFC; mask = 8'hFF;
    idle_bad = 0;
    repeat (4) begin @(negedge clk); if (sd !== 1'b1) idle_bad++; end
    check("R1 idle in reset", idle_bad, 0);
    rst_ni = 1'b1;
    idle_bad = 0;
    repeat (20) begin @(negedge clk); if (sd !== 1'b1) idle_bad++; end
    check("R7 idle before first frame", idle_bad, 0);

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][24:22], VEC[i][21:14], VEC[i][13:6]);
      run_frame(f, he, ie);
      check($sformatf("R2/R3/R4/R5 vector %0d field", i), f, VEC[i][5:0]);
      check($sformatf("R6 vector %0d two-clock bits", i), he, 0);
      check($sformatf("R7 vector %0d idle outside slot", i), ie, 0);
    end

    // R4: low status bits alone never touch the field, all codes
    for (int c = 0; c < 8; c++) begin
      apply(3'(c), 8'h03, 8'hFF);
      run_frame(f, he, ie);
      check($sformatf("R4 code %0d low bits", c), f, (c == 7) ? 6'h00 : 6'h3F);
    end

    // random against model: R2 R3 R5
    for (int i = 0; i < 40; i++) begin
      logic [2:0] c = 3'($urandom);
      logic [7:0] s = 8'($urandom);
      logic [7:0] m = 8'($urandom);
      apply(c, s, m);
      run_frame(f, he, ie);
      check($sformatf("R2/R3/R5 random c=%0d s=%0h m=%0h", c, s, m), f, model(c, s, m));
      check("R6 random two-clock bits", he, 0);
      check("R7 random idle", ie, 0);
    end

    // R6 MSB-first ordering with an asymmetric pattern
    apply(3'd7, 8'h80, 8'hFF);
    run_frame(f, he, ie);
    check("R6 MSB first", f, 6'h20);

    // R8: mid-slot change lands in the next frame
    apply(3'd7, 8'h00, 8'hFF);
    pend_status = 8'hFC;
    pend_en = 1;
    run_frame(f, he, ie);
    check("R8 frozen during slot", f, 6'h00);
    run_frame(f, he, ie);
    check("R8 next frame updated", f, 6'h3F);

    // R1: reset during traffic returns to the idle state
    apply(3'd7, 8'hFC, 8'hFF);
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset output", sd, 1'b1);
    rst_ni = 1'b1;
    idle_bad = 0;
    repeat (10) begin @(negedge clk); if (sd !== 1'b1) idle_bad++; end
    check("R1 idle after reset", idle_bad, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule